// File: doc/BRIEF.md
# Banked Translation-Control Register Access Unit

This unit holds a 32-bit translation-control system register in two physical copies, one for the secure world and one for the non-secure world. Coprocessor move requests arrive on a valid/ready request channel. The unit checks each request against one fixed coprocessor encoding. For a request that matches, it decides whether the access completes, is flagged as an undefined instruction, or traps to the hypervisor level. A completed access is steered to one of the two copies. Every request gets exactly one answer on a valid/ready response channel.

The answer carries the read data, a claimed flag, an undefined flag, a trap flag and a 6-bit syndrome. The request channel is ready whenever the response register is empty or is being drained in the same cycle: `req_ready = !rsp_valid || rsp_ready`. A request is accepted on a rising edge where both `req_valid` and `req_ready` are high. The answer appears in the next cycle. While `rsp_ready` is low, the answer holds unchanged and no new request is taken.

Alongside the access path, the unit decodes one chosen copy into the effective control bits that a translation walker consumes:
- the format bit;
- the two walk-disable bits;
- the two size fields;
- the attribute fields;
- the identifier-select bit;
- the extension enable.

It also gates a companion extension word with the extension enable. Finally, it resolves a table-lookup miss against a base register into either a walk or a fault.

Top module: `xlat_ctl_regunit`

## Requirements
- R1: Only the encoding coprocessor 15, opc1=0, CRn=2, CRm=0, opc2=2 is claimed. Any other encoding answers with claimed, undefined and trap all 0 and read data 0, and changes neither copy.
- R2: A claimed access at level 0, read or write, answers undefined and never trap.
- R3: At level 1, when `lvl2_on` and `trap_group` are both high, reads and writes answer trap with syndrome 0x03. This check comes before all others at level 1. With `lvl2_on` low, `trap_group` has no effect.
- R4: At level 1, with `lvl2_on` high and no group trap, a read traps when `trap_vm_rd` is high and a write traps when `trap_vm_wr` is high. Both traps use syndrome 0x03. Each bit affects only its own direction.
- R5: At levels 1 and 2, a completed access uses copy 1 (non-secure) when `lvl3_is_32` is high. Otherwise it uses the common copy, which is copy 0.
- R6: At level 3, `ns_state`=0 selects copy 0 (secure) and `ns_state`=1 selects copy 1 (non-secure).
- R7: At level 3 with `ns_state`=0, a write answers undefined when `sec_lock_a` or `sec_lock_b` is high. Reads, and writes with `ns_state`=1, are unaffected by these inputs.
- R8: The stored value keeps only the bits that are meaningful for the format chosen by written bit 31, and stores every other bit as 0.
  - Short format (bit 31 = 0): mask 0x8000_0037, that is bits 31, 5, 4 and 2:0.
  - Long format (bit 31 = 1): mask 0xBFC7_3FC7, that is bits 31, 29:22, 18:16, 13:6 and 2:0.
- R9: A write that is claimed, not undefined and not trapped updates its copy at the accepting edge. A read accepted afterwards returns the new value. A read that completes returns its copy's value as it stood at the accepting edge. Writes that are undefined, trapped or unclaimed change nothing.
- R10: The decoded outputs follow copy `ctl_view_ns`.
  - Long format: walk-disable 0/1 come from bits 7/23, sizes from 2:0 and 18:16, attr0 from 13:8, attr1 from 29:24, and the identifier select from bit 22.
  - Short format: walk-disable 0/1 come from bits 4/5, size0 from 2:0, and size1, the attributes and the identifier select read 0.
- R11: The extension enable is bit 6 in the long format and is 0 in the short format. `ext2_eff` equals `ext2_in` when the enable is 1 and is 0 otherwise.
- R12: With `miss_valid` high, a miss against base register `miss_base1` raises `miss_fault` if that base's walk-disable bit is set, and `miss_walk` otherwise. With `miss_valid` low, both outputs are 0.
- R13: `req_ready = !rsp_valid || rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, all response fields hold steady.
- R14: After reset, both copies are 0, `rsp_valid` is 0, and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_lvl | input | 2 | Privilege level of the requester, 0 to 3 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cp | input | 4 | Coprocessor number |
| req_opc1 | input | 3 | First opcode field |
| req_crn | input | 4 | Primary register field |
| req_crm | input | 4 | Secondary register field |
| req_opc2 | input | 3 | Second opcode field |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Answer present |
| rsp_ready | input | 1 | Answer can be taken |
| rsp_claimed | output | 1 | Encoding matched this register |
| rsp_undef | output | 1 | Undefined-instruction outcome |
| rsp_trap | output | 1 | Trap-to-hypervisor outcome |
| rsp_syndrome | output | 6 | Trap syndrome code, 0 without a trap |
| rsp_rdata | output | 32 | Read data of a completed read, 0 otherwise |
| lvl2_on | input | 1 | Hypervisor level enabled |
| trap_group | input | 1 | Coprocessor-group trap control |
| trap_vm_rd | input | 1 | Read trap for memory-control registers |
| trap_vm_wr | input | 1 | Write trap for memory-control registers |
| lvl3_is_32 | input | 1 | Level 3 present and running 32-bit |
| ns_state | input | 1 | Non-secure state flag |
| sec_lock_a | input | 1 | First secure-write disable |
| sec_lock_b | input | 1 | Second secure-write disable |
| ctl_view_ns | input | 1 | Copy that drives the decoded outputs |
| ext2_in | input | 32 | Companion extension word |
| ctl_long | output | 1 | Long format active |
| ctl_walk_dis0 | output | 1 | Walk disable for base 0 |
| ctl_walk_dis1 | output | 1 | Walk disable for base 1 |
| ctl_size0 | output | 3 | Size field for base 0 |
| ctl_size1 | output | 3 | Size field for base 1 |
| ctl_ext_en | output | 1 | Effective extension enable |
| ctl_asid_sel | output | 1 | Identifier-select bit |
| ctl_attr0 | output | 6 | Walk attributes for base 0 |
| ctl_attr1 | output | 6 | Walk attributes for base 1 |
| ext2_eff | output | 32 | Gated companion word |
| miss_valid | input | 1 | Lookup miss present |
| miss_base1 | input | 1 | Miss falls in the base-1 range |
| miss_fault | output | 1 | Miss becomes a translation fault |
| miss_walk | output | 1 | Miss starts a table walk |

## Verification
The assertions check the following on every cycle:
- the answer holds steady under back-pressure;
- undefined and trap are never raised together;
- the syndrome value on a trap;
- level-0 and secure-locked writes answering undefined;
- stored copies with no write pending staying unchanged;
- no bit outside the active format's mask ever being held;
- a pending miss yielding exactly one of fault or walk.

Only the bench scenarios show the following:
- the ordering of the level-1 trap chain;
- which copy each level and security setting reaches;
- the exact masked values read back;
- the decoded fields for each format.

// File: rtl/xlat_ctl_pkg.sv
package xlat_ctl_pkg;
  localparam int CTL_W = 32;

  localparam logic [CTL_W-1:0] SHORT_KEEP = 32'h8000_0037;
  localparam logic [CTL_W-1:0] LONG_KEEP  = 32'hBFC7_3FC7;

  localparam logic BANK_SEC    = 1'b0;
  localparam logic BANK_NS     = 1'b1;
  localparam logic BANK_COMMON = 1'b0;

  typedef enum logic [1:0] {LVL_USER = 2'd0, LVL_OS = 2'd1, LVL_HYP = 2'd2, LVL_MON = 2'd3} lvl_e;

  typedef struct packed {
    logic claimed;
    logic undef;
    logic trap;
    logic do_wr;
    logic do_rd;
    logic bank;
  } acc_res_t;

  typedef struct packed {
    logic       long_fmt;
    logic       wdis0;
    logic       wdis1;
    logic [2:0] sz0;
    logic [2:0] sz1;
    logic       ext_en;
    logic       asid_sel;
    logic [5:0] attr0;
    logic [5:0] attr1;
  } ctl_t;

  function automatic logic [CTL_W-1:0] keep_bits(input logic [CTL_W-1:0] w);
    return w & (w[CTL_W-1] ? LONG_KEEP : SHORT_KEEP);
  endfunction
endpackage

// File: rtl/xlat_ctl_resolve.sv
module xlat_ctl_resolve
  import xlat_ctl_pkg::*;
#(
  parameter logic [3:0] CP_ID   = 4'd15,
  parameter logic [2:0] OPC1_ID = 3'd0,
  parameter logic [3:0] CRN_ID  = 4'd2,
  parameter logic [3:0] CRM_ID  = 4'd0,
  parameter logic [2:0] OPC2_ID = 3'd2
) (
  input  logic [1:0] lvl,
  input  logic       wr,
  input  logic [3:0] cp,
  input  logic [2:0] opc1,
  input  logic [3:0] crn,
  input  logic [3:0] crm,
  input  logic [2:0] opc2,
  input  logic       lvl2_on,
  input  logic       trap_group,
  input  logic       trap_vm_rd,
  input  logic       trap_vm_wr,
  input  logic       lvl3_is_32,
  input  logic       ns_state,
  input  logic       sec_lock_a,
  input  logic       sec_lock_b,
  output acc_res_t   res
);
  logic hit;
  logic vm_trap;
  logic shared_bank;

  assign hit = (cp == CP_ID) && (opc1 == OPC1_ID) && (crn == CRN_ID) &&
               (crm == CRM_ID) && (opc2 == OPC2_ID);
  assign vm_trap     = wr ? trap_vm_wr : trap_vm_rd;
  assign shared_bank = lvl3_is_32 ? BANK_NS : BANK_COMMON;

  // Prioritised chain per level; the level-1 group trap is checked first.
  always_comb begin
    res = '0;
    res.claimed = hit;
    if (hit) begin
      case (lvl_e'(lvl))
        LVL_USER: res.undef = 1'b1;
        LVL_OS: begin
          if (lvl2_on && trap_group)   res.trap = 1'b1;
          else if (lvl2_on && vm_trap) res.trap = 1'b1;
          else                         res.bank = shared_bank;
        end
        LVL_HYP: res.bank = shared_bank;
        default: begin
          res.bank = ns_state ? BANK_NS : BANK_SEC;
          if (wr && !ns_state && (sec_lock_a || sec_lock_b)) res.undef = 1'b1;
        end
      endcase
    end
    res.do_wr = hit && wr  && !res.undef && !res.trap;
    res.do_rd = hit && !wr && !res.undef && !res.trap;
  end
endmodule

// File: rtl/xlat_ctl_banks.sv
module xlat_ctl_banks
  import xlat_ctl_pkg::*;
#(
  parameter int NB = 2,
  localparam int SW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SW-1:0]    wr_sel,
  input  logic [CTL_W-1:0] wr_data,
  output logic [CTL_W-1:0] q [NB]
);
  logic [CTL_W-1:0] kept;
  assign kept = keep_bits(wr_data);

  for (genvar b = 0; b < NB; b++) begin : g_copy
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           q[b] <= '0;
      else if (wr_en && wr_sel == SW'(b))   q[b] <= kept;
    end

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_sel == SW'(b)) |=> $stable(q[b]));

    p_resv_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (q[b] & ~(q[b][CTL_W-1] ? LONG_KEEP : SHORT_KEEP)) == '0);
  end
endmodule

// File: rtl/xlat_ctl_fields.sv
module xlat_ctl_fields
  import xlat_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CTL_W-1:0] word,
  input  logic [CTL_W-1:0] ext2_in,
  input  logic             miss_valid,
  input  logic             miss_base1,
  output ctl_t             ctl,
  output logic [CTL_W-1:0] ext2_eff,
  output logic             miss_fault,
  output logic             miss_walk
);
  logic lf;
  logic dis_hit;
  assign lf = word[31];

  always_comb begin
    ctl          = '0;
    ctl.long_fmt = lf;
    ctl.sz0      = word[2:0];
    if (lf) begin
      ctl.wdis0    = word[7];
      ctl.wdis1    = word[23];
      ctl.sz1      = word[18:16];
      ctl.ext_en   = word[6];
      ctl.asid_sel = word[22];
      ctl.attr0    = word[13:8];
      ctl.attr1    = word[29:24];
    end else begin
      ctl.wdis0 = word[4];
      ctl.wdis1 = word[5];
    end
  end

  assign ext2_eff   = ctl.ext_en ? ext2_in : '0;
  assign dis_hit    = miss_base1 ? ctl.wdis1 : ctl.wdis0;
  assign miss_fault = miss_valid && dis_hit;
  assign miss_walk  = miss_valid && !dis_hit;

  p_miss_one_r12: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid |-> $countones({miss_fault, miss_walk}) == 1);

  p_miss_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !miss_valid |-> !(miss_fault || miss_walk));
endmodule

// File: rtl/xlat_ctl_regunit.sv
module xlat_ctl_regunit
  import xlat_ctl_pkg::*;
#(
  parameter int         SYN_W     = 6,
  parameter logic [5:0] TRAP_CODE = 6'h03,
  parameter int         NB        = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_lvl,
  input  logic             req_write,
  input  logic [3:0]       req_cp,
  input  logic [2:0]       req_opc1,
  input  logic [3:0]       req_crn,
  input  logic [3:0]       req_crm,
  input  logic [2:0]       req_opc2,
  input  logic [31:0]      req_wdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_claimed,
  output logic             rsp_undef,
  output logic             rsp_trap,
  output logic [SYN_W-1:0] rsp_syndrome,
  output logic [31:0]      rsp_rdata,
  input  logic             lvl2_on,
  input  logic             trap_group,
  input  logic             trap_vm_rd,
  input  logic             trap_vm_wr,
  input  logic             lvl3_is_32,
  input  logic             ns_state,
  input  logic             sec_lock_a,
  input  logic             sec_lock_b,
  input  logic             ctl_view_ns,
  input  logic [31:0]      ext2_in,
  output logic             ctl_long,
  output logic             ctl_walk_dis0,
  output logic             ctl_walk_dis1,
  output logic [2:0]       ctl_size0,
  output logic [2:0]       ctl_size1,
  output logic             ctl_ext_en,
  output logic             ctl_asid_sel,
  output logic [5:0]       ctl_attr0,
  output logic [5:0]       ctl_attr1,
  output logic [31:0]      ext2_eff,
  input  logic             miss_valid,
  input  logic             miss_base1,
  output logic             miss_fault,
  output logic             miss_walk
);
  localparam int SW = (NB > 1) ? $clog2(NB) : 1;

  acc_res_t         res;
  ctl_t             ctl;
  logic             accept;
  logic [CTL_W-1:0] copy_q [NB];
  logic [CTL_W-1:0] view_word;

  xlat_ctl_resolve u_resolve (
    .lvl(req_lvl), .wr(req_write), .cp(req_cp), .opc1(req_opc1),
    .crn(req_crn), .crm(req_crm), .opc2(req_opc2),
    .lvl2_on(lvl2_on), .trap_group(trap_group), .trap_vm_rd(trap_vm_rd),
    .trap_vm_wr(trap_vm_wr), .lvl3_is_32(lvl3_is_32), .ns_state(ns_state),
    .sec_lock_a(sec_lock_a), .sec_lock_b(sec_lock_b), .res(res)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  xlat_ctl_banks #(.NB(NB)) u_banks (
    .clk(clk), .rst_n(rst_n),
    .wr_en(accept && res.do_wr), .wr_sel(SW'(res.bank)),
    .wr_data(req_wdata), .q(copy_q)
  );

  // Response register: loads on accept, clears once drained.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_claimed  <= 1'b0;
      rsp_undef    <= 1'b0;
      rsp_trap     <= 1'b0;
      rsp_syndrome <= '0;
      rsp_rdata    <= '0;
    end else if (accept) begin
      rsp_valid    <= 1'b1;
      rsp_claimed  <= res.claimed;
      rsp_undef    <= res.undef;
      rsp_trap     <= res.trap;
      rsp_syndrome <= res.trap ? TRAP_CODE[SYN_W-1:0] : '0;
      rsp_rdata    <= res.do_rd ? copy_q[SW'(res.bank)] : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign view_word = copy_q[SW'(ctl_view_ns)];

  xlat_ctl_fields u_fields (
    .clk(clk), .rst_n(rst_n), .word(view_word), .ext2_in(ext2_in),
    .miss_valid(miss_valid), .miss_base1(miss_base1), .ctl(ctl),
    .ext2_eff(ext2_eff), .miss_fault(miss_fault), .miss_walk(miss_walk)
  );

  assign ctl_long      = ctl.long_fmt;
  assign ctl_walk_dis0 = ctl.wdis0;
  assign ctl_walk_dis1 = ctl.wdis1;
  assign ctl_size0     = ctl.sz0;
  assign ctl_size1     = ctl.sz1;
  assign ctl_ext_en    = ctl.ext_en;
  assign ctl_asid_sel  = ctl.asid_sel;
  assign ctl_attr0     = ctl.attr0;
  assign ctl_attr1     = ctl.attr1;

  p_stall_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) &&
      $stable(rsp_undef) && $stable(rsp_trap) && $stable(rsp_claimed)));

  p_one_outcome_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_undef && rsp_trap));

  p_user_undef_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_lvl == 2'd0 && req_cp == 4'd15 && req_opc1 == 3'd0 &&
     req_crn == 4'd2 && req_crm == 4'd0 && req_opc2 == 3'd2) |=> rsp_undef);

  p_trap_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_trap) |-> rsp_syndrome == TRAP_CODE[SYN_W-1:0]);

  p_sec_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && res.claimed && req_lvl == 2'd3 && req_write && !ns_state &&
     (sec_lock_a || sec_lock_b)) |=> (rsp_undef && !rsp_trap));
endmodule

// File: tb/test_xlat_ctl_regunit.sv
`timescale 1ns/1ps
module test_xlat_ctl_regunit;
  logic clk = 0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic req_valid, req_ready, req_write, rsp_valid, rsp_ready;
  logic [1:0] req_lvl;
  logic [3:0] req_cp, req_crn, req_crm;
  logic [2:0] req_opc1, req_opc2;
  logic [31:0] req_wdata, rsp_rdata, ext2_in, ext2_eff;
  logic rsp_claimed, rsp_undef, rsp_trap;
  logic [5:0] rsp_syndrome, ctl_attr0, ctl_attr1;
  logic lvl2_on, trap_group, trap_vm_rd, trap_vm_wr, lvl3_is_32, ns_state;
  logic sec_lock_a, sec_lock_b, ctl_view_ns;
  logic ctl_long, ctl_walk_dis0, ctl_walk_dis1, ctl_ext_en, ctl_asid_sel;
  logic [2:0] ctl_size0, ctl_size1;
  logic miss_valid, miss_base1, miss_fault, miss_walk;

  xlat_ctl_regunit i_xlat_ctl_regunit (.*);

  int total = 0, bad = 0;
  logic [31:0] mb [2];

  task automatic chk(input bit ok, input string what, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, got, exp);
    end
  endtask

  function automatic logic [31:0] keep(input logic [31:0] w);
    if (w[31]) return w & 32'hBFC7_3FC7;
    return w & 32'h8000_0037;
  endfunction

  // Model of the decoded outputs, compared on every clock (R10, R11, R12).
  always @(negedge clk) if (rst_n) begin
    logic [31:0] w;
    logic lf, d0, d1, en;
    logic [26:0] e, g;
    w  = mb[ctl_view_ns];
    lf = w[31];
    d0 = lf ? w[7] : w[4];
    d1 = lf ? w[23] : w[5];
    en = lf & w[6];
    e = {lf, d0, d1, w[2:0], lf ? w[18:16] : 3'd0, en, lf & w[22],
         lf ? w[13:8] : 6'd0, lf ? w[29:24] : 6'd0};
    g = {ctl_long, ctl_walk_dis0, ctl_walk_dis1, ctl_size0, ctl_size1, ctl_ext_en,
         ctl_asid_sel, ctl_attr0, ctl_attr1};
    chk(g == e, "R10 decoded fields", 64'(g), 64'(e));
    chk(ext2_eff == (en ? ext2_in : 32'd0), "R11 ext2_eff", 64'(ext2_eff), 64'(en ? ext2_in : 32'd0));
    chk({miss_fault, miss_walk} == {miss_valid & (miss_base1 ? d1 : d0), miss_valid & !(miss_base1 ? d1 : d0)},
        "R12 miss routing", 64'({miss_fault, miss_walk}),
        64'({miss_valid & (miss_base1 ? d1 : d0), miss_valid & !(miss_base1 ? d1 : d0)}));
  end

  task automatic acc(input logic [1:0] lvl, input logic wr, input bit hit, input logic [31:0] wd, input string tag);
    logic u, t, b, claim, done;
    logic [31:0] erd;
    claim = hit; u = 0; t = 0; b = 0;
    if (hit) begin
      if (lvl == 0) u = 1;
      else if (lvl == 1 && lvl2_on && (trap_group || (wr ? trap_vm_wr : trap_vm_rd))) t = 1;
      else if (lvl != 3) b = lvl3_is_32;
      else begin
        b = ns_state;
        if (wr && !ns_state && (sec_lock_a || sec_lock_b)) u = 1;
      end
    end
    done = hit && !u && !t;
    erd = (done && !wr) ? mb[b] : 32'd0;
    @(negedge clk);
    req_lvl = lvl; req_write = wr; req_wdata = wd;
    req_cp = 4'd15; req_opc1 = 3'd0; req_crn = hit ? 4'd2 : 4'd3; req_crm = 4'd0; req_opc2 = 3'd2;
    req_valid = 1;
    @(posedge clk);
    if (done && wr) mb[b] = keep(wd);
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid == 1, {tag, " rsp_valid"}, 64'(rsp_valid), 64'd1);
    chk({rsp_claimed, rsp_undef, rsp_trap} == {claim, u, t}, {tag, " outcome"},
        64'({rsp_claimed, rsp_undef, rsp_trap}), 64'({claim, u, t}));
    chk(rsp_syndrome == (t ? 6'h03 : 6'h00), {tag, " syndrome"}, 64'(rsp_syndrome), 64'(t ? 6'h03 : 6'h00));
    chk(rsp_rdata == erd, {tag, " rdata"}, 64'(rsp_rdata), 64'(erd));
  endtask

  task automatic rd_expect(input logic [1:0] lvl, input logic [31:0] exp, input string tag);
    acc(lvl, 0, 1, 0, tag);
    chk(rsp_rdata == exp, {tag, " readback"}, 64'(rsp_rdata), 64'(exp));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    mb[0] = 0; mb[1] = 0;
    rst_n = 0; req_valid = 0; rsp_ready = 1; req_lvl = 0; req_write = 0;
    req_cp = 0; req_opc1 = 0; req_crn = 0; req_crm = 0; req_opc2 = 0; req_wdata = 0;
    lvl2_on = 0; trap_group = 0; trap_vm_rd = 0; trap_vm_wr = 0; lvl3_is_32 = 0;
    ns_state = 0; sec_lock_a = 0; sec_lock_b = 0; ctl_view_ns = 0; ext2_in = 32'h1234_5678;
    miss_valid = 1; miss_base1 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R14 reset state
    chk(rsp_valid == 0, "R14 rsp_valid after reset", 64'(rsp_valid), 0);
    chk(req_ready == 1, "R14 req_ready after reset", 64'(req_ready), 1);
    rd_expect(1, 0, "R14 copy0 zero");
    ns_state = 1; rd_expect(3, 0, "R14 copy1 zero"); ns_state = 0;

    // R8/R9 masking in both formats, common copy at level 1 (R5)
    acc(1, 1, 1, 32'hFFFF_FFFF, "R8 long write");
    rd_expect(1, 32'hBFC7_3FC7, "R8 long mask");
    miss_base1 = 1; @(negedge clk);
    acc(2, 1, 1, 32'h7FFF_FFFF, "R8 short write");
    rd_expect(2, 32'h0000_0037, "R8 short mask");
    // R1 unclaimed encoding
    acc(1, 1, 0, 32'h8000_0080, "R1 unclaimed write");
    rd_expect(1, 32'h0000_0037, "R1 no change");
    // R2 level 0
    acc(0, 0, 1, 0, "R2 read lvl0");
    acc(0, 1, 1, 32'h8000_0001, "R2 write lvl0");
    rd_expect(1, 32'h0000_0037, "R2 no change");
    // R3 group trap first, gated by lvl2_on
    trap_group = 1;
    acc(1, 1, 1, 32'h8000_0001, "R3 no hyp write");
    rd_expect(1, 32'h8000_0001, "R3 no hyp readback");
    lvl2_on = 1; trap_vm_rd = 0; trap_vm_wr = 0;
    acc(1, 0, 1, 0, "R3 group trap read");
    acc(1, 1, 1, 32'h8000_0002, "R3 group trap write");
    acc(2, 0, 1, 0, "R3 lvl2 unaffected");
    trap_group = 0;
    // R4 per-direction traps
    trap_vm_wr = 1;
    acc(1, 1, 1, 32'h8000_0003, "R4 write trap");
    rd_expect(1, 32'h8000_0001, "R4 read passes");
    trap_vm_wr = 0; trap_vm_rd = 1;
    acc(1, 0, 1, 0, "R4 read trap");
    acc(1, 1, 1, 32'h8000_00C4, "R4 write passes");
    trap_vm_rd = 0; lvl2_on = 0;
    rd_expect(1, 32'h8000_00C4, "R4 readback");
    ext2_in = 32'hCAFE_0001; miss_base1 = 0; @(negedge clk);
    // R5 non-secure copy when level 3 is 32-bit; R6 level 3 selection
    lvl3_is_32 = 1;
    acc(2, 1, 1, 32'h0000_0010, "R5 ns write");
    ctl_view_ns = 1; @(negedge clk);
    ns_state = 1; rd_expect(3, 32'h0000_0010, "R6 ns copy");
    ns_state = 0; rd_expect(3, 32'h8000_00C4, "R6 sec copy");
    rd_expect(1, 32'h0000_0010, "R5 lvl1 ns copy");
    // R7 secure locks
    sec_lock_a = 1;
    acc(3, 1, 1, 32'h8000_0007, "R7 lock a write");
    rd_expect(3, 32'h8000_00C4, "R7 read unaffected");
    ns_state = 1;
    acc(3, 1, 1, 32'h8080_0000, "R7 ns write unaffected");
    sec_lock_a = 0; sec_lock_b = 1; ns_state = 0;
    acc(3, 1, 1, 32'h8000_0007, "R7 lock b write");
    sec_lock_b = 0;
    acc(3, 1, 1, 32'h8000_0007, "R7 unlocked write");
    ctl_view_ns = 0; miss_base1 = 1; @(negedge clk);
    miss_valid = 0; @(negedge clk);
    miss_valid = 1; ctl_view_ns = 1; @(negedge clk);
    // R13 back-pressure
    lvl3_is_32 = 0;
    @(negedge clk); rsp_ready = 0;
    acc(1, 0, 1, 0, "R13 stalled read");
    chk(req_ready == 0, "R13 req_ready low", 64'(req_ready), 0);
    req_lvl = 1; req_write = 1; req_wdata = 32'h8000_0005; req_crn = 4'd2; req_valid = 1;
    @(negedge clk);
    chk(rsp_valid == 1 && rsp_rdata == 32'h8000_0007, "R13 held answer", 64'(rsp_rdata), 64'h8000_0007);
    chk(req_ready == 0, "R13 still stalled", 64'(req_ready), 0);
    rsp_ready = 1;
    @(posedge clk);
    mb[0] = 32'h8000_0005;
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid == 1 && rsp_claimed == 1 && rsp_rdata == 0, "R13 second answer",
        64'({rsp_valid, rsp_claimed, rsp_rdata}), 64'({2'b11, 32'd0}));
    rd_expect(1, 32'h8000_0005, "R13 write once");
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule